// File: doc/BRIEF.md
# Paired-Sample DC-Balanced Serializer

This block drains one frame of 14-bit channel samples from a group of 256 channels onto a single serial lane. Each frame begins with a strobe. The block then reads the channel samples through a simple read port, which presents an address and receives the data in the same cycle. It packs the samples two at a time into 32-bit words and shifts each word out most-significant bit first, one bit per clock. A frame is 128 words long, so the bit clock must run at least 32 × 128 times the frame rate plus a few cycles of start-up. A chip uses two instances, one for each lane, and each instance covers a 16 by 16 group of channels.

Every word holds an inversion flag, a fixed three-bit framing pattern and the two samples. The block keeps a running count of ones minus zeros across every word it has sent. When the 28 sample bits would push that count further away from zero, it sends them complemented and sets the flag, so the line stays DC-balanced. A marker output rises for the first bit of every word. A receiver uses the marker to find word boundaries and the flag to undo the inversion.

Top module: `pair_serializer`

## Requirements
- R1: While reset is held low, ser_out, word_mark and rd_addr are all 0. The running disparity starts at 0, so the first word after reset is never inverted.
- R2: Each word has the following layout. Bit 31 is the inversion flag. Bits 30..28 are the constant pattern 1,0,1. Bits 13..0 hold the even (lower-numbered) channel and bits 27..14 hold the odd channel, each complemented when the flag is 1.
- R3: Let d be the count of ones minus the count of zeros in the 28 uninverted sample bits. The sample bits are inverted and the flag is 1 exactly when d and the running disparity are both positive or both negative. If either one is zero, the bits are not inverted.
- R4: After each word the running disparity grows by the ones-minus-zeros count of all 32 sent bits. The disparity is kept across frames and stays within ±32.
- R5: A frame sends 128 words carrying channels 0 to 255 in ascending order, two per word, with channels 0 and 1 in the first word.
- R6: Bits leave MSB first, one per clock. word_mark is high only during the cycle that carries bit 31, so marks inside a frame are exactly 32 cycles apart.
- R7: A strobe accepted in cycle k makes rd_addr 0 in cycle k+1 and 1 in cycle k+2. Bit 31 of the first word is sent, with word_mark high, in cycle k+4. rd_data must be valid in the same cycle that its address is presented.
- R8: A strobe that arrives while a frame is still in progress, before the last bit of the last word, is dropped. It neither restarts the frame nor starts a new one afterwards.
- R9: A strobe that arrives during the cycle carrying the last bit of the last word is accepted, and the next frame's first mark follows 4 cycles later.
- R10: Between frames, ser_out and word_mark stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe that starts a frame |
| rd_addr | output | 8 | Channel index presented to the sample store |
| rd_data | input | 14 | Sample of channel rd_addr, valid in the same cycle |
| ser_out | output | 1 | Serial data bit |
| word_mark | output | 1 | High during bit 31 of each word |

## Verification
Two functions can fall in the same cycle: the end of a frame on its final bit, and the acceptance of a new frame strobe. The bench raises the strobe in exactly that final cycle. It counts the cycle from the first mark of the frame, then expects the next frame's first mark four cycles later. It then compares both frames word for word against a bench model whose disparity runs on from one frame into the next. It also raises a strobe in the middle of a frame to confirm that the strobe is dropped and not held over for later.

// File: rtl/pair_serializer.sv
module pair_serializer #(
  parameter int SAMPLE_W = 14,
  parameter int NUM_CH   = 256,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  output logic [CH_W-1:0]     rd_addr,
  input  logic [SAMPLE_W-1:0] rd_data,
  output logic                ser_out,
  output logic                word_mark
);
  localparam int DATA_W = 2 * SAMPLE_W;
  localparam int WORD_W = DATA_W + 4;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int WORDS  = NUM_CH / 2;
  localparam int WI_W   = $clog2(WORDS);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int DISP_W = $clog2(WORD_W) + 3;

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_LOAD, S_SEND} state_t;

  state_t                     state;
  logic [BIT_W-1:0]           bit_idx;
  logic [WI_W-1:0]            word_idx;
  logic [SAMPLE_W-1:0]        lo_q, hi_q;
  logic [WORD_W-1:0]          sh;
  logic signed [DISP_W-1:0]   disp;

  function automatic logic [CNT_W-1:0] count_ones(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < DATA_W; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  logic [DATA_W-1:0]        pair;
  logic [CNT_W-1:0]         ones;
  logic signed [DISP_W-1:0] dd;
  logic                     inv;
  logic [WORD_W-1:0]        enc_word;
  logic signed [DISP_W-1:0] disp_next;
  int                       word_ones;

  assign pair     = {hi_q, lo_q};
  assign ones     = count_ones(pair);
  assign dd       = DISP_W'(2 * int'(ones) - DATA_W);
  assign inv      = (dd > 0 && disp > 0) || (dd < 0 && disp < 0);
  assign enc_word = {inv, 3'b101, inv ? ~pair : pair};
  assign word_ones = inv ? (DATA_W - int'(ones) + 3) : (int'(ones) + 2);
  assign disp_next = DISP_W'(int'(disp) + 2 * word_ones - WORD_W);

  logic last_bit, last_word, frame_end, accept;
  assign last_bit  = (state == S_SEND) && (bit_idx == BIT_W'(WORD_W - 1));
  assign last_word = (word_idx == WI_W'(WORDS - 1));
  assign frame_end = last_bit && last_word;
  assign accept    = frame_start && ((state == S_IDLE) || frame_end);

  always_comb begin
    case (state)
      S_HI:    rd_addr = CH_W'(1);
      S_SEND:  rd_addr = CH_W'({word_idx + 1'b1, bit_idx == BIT_W'(1)});
      default: rd_addr = '0;
    endcase
  end

  assign ser_out   = sh[WORD_W-1];
  assign word_mark = (state == S_SEND) && (bit_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bit_idx  <= '0;
      word_idx <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      sh       <= '0;
      disp     <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) state <= S_LO;
        S_LO: begin
          lo_q  <= rd_data;
          state <= S_HI;
        end
        S_HI: begin
          hi_q  <= rd_data;
          state <= S_LOAD;
        end
        S_LOAD: begin
          sh       <= enc_word;
          disp     <= disp_next;
          bit_idx  <= '0;
          word_idx <= '0;
          state    <= S_SEND;
        end
        default: begin
          if (bit_idx == '0) lo_q <= rd_data;
          if (bit_idx == BIT_W'(1)) hi_q <= rd_data;
          if (last_bit) begin
            bit_idx <= '0;
            if (last_word) begin
              sh    <= '0;
              state <= accept ? S_LO : S_IDLE;
            end else begin
              sh       <= enc_word;
              disp     <= disp_next;
              word_idx <= word_idx + 1'b1;
            end
          end else begin
            sh      <= sh << 1;
            bit_idx <= bit_idx + 1'b1;
          end
        end
      endcase
    end
  end

  assert_frame_hi1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_mark |=> ser_out);
  assert_frame_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(word_mark, 2) |-> !ser_out);
  assert_frame_hi2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(word_mark, 3) |-> ser_out);
  assert_disp_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(disp) <= WORD_W) && (int'(disp) >= -WORD_W));
  assert_mark_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_mark |=> !word_mark);
  assert_strobe_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SEND && !frame_end && frame_start) |=> (state == S_SEND));
  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && frame_start) |=> (state == S_LO));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (!ser_out && !word_mark));
endmodule

// File: tb/tb_pair_serializer.sv
module tb_pair_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 14;
  localparam int NCH = 256;
  localparam int NW = NCH / 2;
  localparam int WATCHDOG = 150000;

  logic clk = 0, rst_n = 0, frame_start = 0;
  logic [7:0] rd_addr;
  logic [SW-1:0] rd_data;
  logic ser_out, word_mark;

  logic [SW-1:0] mem [0:NCH-1];
  assign rd_data = mem[rd_addr];

  pair_serializer dut (.clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .rd_addr(rd_addr), .rd_data(rd_data), .ser_out(ser_out), .word_mark(word_mark));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Capture of serial words at the falling edge
  logic [31:0] cap [0:2047];
  int ncap = 0, bitn = 0, line_disp = 0, max_abs = 0, mid_marks = 0;
  logic [31:0] cur;
  always @(negedge clk) begin
    if (rst_n) begin
      if (word_mark) begin
        if (bitn != 0) mid_marks++;
        cur = {31'b0, ser_out};
        bitn = 1;
      end else if (bitn > 0 && bitn < 32) begin
        cur = {cur[30:0], ser_out};
        bitn++;
      end
      if (bitn == 32) begin
        cap[ncap] = cur;
        ncap++;
        bitn = 0;
        line_disp += 2 * $countones(cur) - 32;
        if (line_disp > max_abs) max_abs = line_disp;
        if (-line_disp > max_abs) max_abs = -line_disp;
      end
    end
  end

  // Reference model
  logic [31:0] exp_w [0:NW-1];
  int ref_disp = 0;

  function automatic logic [SW-1:0] fill(input int kind, input logic [SW-1:0] val, input int ch);
    case (kind)
      0: return val;
      1: return SW'(ch * int'(val));
      2: return ch[0] ? ~val : val;
      default: return SW'((ch * ch * 7 + ch * int'(val)) ^ int'(val));
    endcase
  endfunction

  task automatic load_mem(input int kind, input logic [SW-1:0] val);
    for (int c = 0; c < NCH; c++) mem[c] = fill(kind, val, c);
  endtask

  task automatic build_expected();
    for (int w = 0; w < NW; w++) begin
      logic [27:0] d;
      int dd;
      bit iv;
      d = {mem[2*w+1], mem[2*w]};
      dd = 2 * $countones(d) - 28;
      iv = (dd > 0 && ref_disp > 0) || (dd < 0 && ref_disp < 0);
      exp_w[w] = {iv, 3'b101, iv ? ~d : d};
      ref_disp += 2 * $countones(exp_w[w]) - 32;
    end
  endtask

  task automatic start_frame(output int mcyc);
    int s;
    @(negedge clk); frame_start = 1; s = cyc;
    @(negedge clk); frame_start = 0;
    chk(rd_addr == 0, "R7", "first fetch address", 32'(rd_addr), 0);
    @(negedge clk);
    chk(rd_addr == 1, "R7", "second fetch address", 32'(rd_addr), 1);
    @(negedge clk);
    @(negedge clk);
    chk(word_mark && cyc == s + 4, "R7", "first mark delay", 32'(cyc - s), 4);
    mcyc = cyc;
  endtask

  task automatic compare_frame(input int base);
    while (ncap < base + NW) @(negedge clk);
    for (int w = 0; w < NW; w++)
      chk(cap[base + w] == exp_w[w], "R2 R3 R5 R6", $sformatf("word %0d", w),
          cap[base + w], exp_w[w]);
  endtask

  typedef logic [17:0] pat_t;
  localparam pat_t PATS [0:5] = '{
    {4'd0, 14'h0000}, {4'd0, 14'h3FFF}, {4'd1, 14'h0001},
    {4'd2, 14'h2AAA}, {4'd3, 14'h1234}, {4'd3, 14'h0F0F}
  };

  initial begin
    int m, base, target, bad;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!ser_out && !word_mark && rd_addr == 0, "R1", "outputs in reset",
        {22'b0, rd_addr, ser_out, word_mark}, 0);
    rst_n = 1;
    // R10: idle after reset
    bad = 0;
    repeat (20) begin @(negedge clk); if (ser_out || word_mark) bad++; end
    chk(bad == 0, "R10", "idle after reset", bad, 0);

    // Table-driven frames
    for (int p = 0; p < 6; p++) begin
      load_mem(int'(PATS[p][17:14]), PATS[p][13:0]);
      build_expected();
      base = ncap;
      start_frame(m);
      compare_frame(base);
      if (p == 0) begin
        chk(cap[0][31] == 1'b0, "R1", "first word flag after reset", cap[0][31], 0);
        chk(cap[1][31] == 1'b1, "R3", "zero data with negative disparity inverts", cap[1][31], 1);
      end
      bad = 0;
      repeat (10) begin @(negedge clk); if (ser_out || word_mark) bad++; end
      chk(bad == 0, "R10", "idle between frames", bad, 0);
    end

    // R8: strobe in the middle of a frame is dropped
    load_mem(3, 14'h0777);
    build_expected();
    base = ncap;
    start_frame(m);
    repeat (1000) @(negedge clk);
    frame_start = 1; @(negedge clk); frame_start = 0;
    compare_frame(base);
    bad = 0;
    repeat (300) begin @(negedge clk); if (ser_out || word_mark) bad++; end
    chk(ncap == base + NW, "R8", "no extra words after dropped strobe", ncap - base, NW);
    chk(bad == 0, "R8", "line quiet after dropped strobe", bad, 0);

    // R9: strobe on the final bit of a frame
    load_mem(1, 14'h0135);
    build_expected();
    base = ncap;
    start_frame(m);
    target = m + (NW - 1) * 32 + 31;
    while (cyc < target) @(negedge clk);
    chk(!word_mark && cyc == target, "R9", "final bit cycle reached", cyc, target);
    frame_start = 1; @(negedge clk); frame_start = 0;
    while (cyc < target + 4) @(negedge clk);
    chk(word_mark, "R9", "next frame mark 4 cycles after final bit", word_mark, 1);
    compare_frame(base);
    build_expected();
    compare_frame(base + NW);

    // R4, R6
    chk(max_abs <= 32, "R4", "line disparity bound", max_abs, 32);
    chk(mid_marks == 0, "R6", "marks only at word starts", mid_marks, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    while (cyc < WATCHDOG) @(negedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule